// File: doc/BRIEF.md
# Binary Extension Field Inverter

This block is a sequential unit that finds the multiplicative inverse of an element of GF(2^m), for a field degree m picked per operation. The field is given as the complete reduction polynomial, including its leading term at bit m. The unit never computes a degree and never shifts by a variable distance. It keeps four working polynomials and a small signed-style balance counter, and it advances them once per clock. Each step tests only bit m of two registers and then applies an XOR, a one-place shift or a register swap.

A caller raises `start_i` for one cycle while the unit is idle. It presents the element, the polynomial and the degree in that same cycle. After exactly 2m further clock edges `done_o` pulses for one cycle and `inv_o` carries the inverse. The result stays on `inv_o` until the next completion. A zero element has no inverse, so the unit reports zero for it, with the same latency and the same handshake. The degree must lie between 2 and `MAX_DEG`.

Top module: `gfinv_unit`

## Requirements
- R1: After reset, `done_o` and `busy_o` are low and `inv_o` is zero.
- R2: A start accepted at clock edge E0 makes `done_o` high after edge E0+2m, where m is the degree captured with the start. `done_o` is low in every cycle between.
- R3: For a nonzero element a and an irreducible polynomial of degree m, the product of a and `inv_o` reduced by the polynomial equals 1.
- R4: At completion, every bit of `inv_o` at position m or above is zero.
- R5: For an element equal to zero, `inv_o` is zero at completion, with the latency of R2.
- R6: While `busy_o` is high, `start_i` is ignored. The running operation keeps its operands, its result and its completion cycle.
- R7: `inv_o` keeps its value in every cycle except the one that follows a completing edge, including while a new operation runs.
- R8: `done_o` is high for exactly one cycle per operation.
- R9: `busy_o` is high from the edge that accepts a start until the completing edge. It is low in the cycle in which `done_o` is high, so a new start is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; honoured only when not busy |
| elem_i | input | MAX_DEG | Element to invert, in the low m bits |
| poly_i | input | MAX_DEG+1 | Full reduction polynomial with its top bit at position m |
| deg_i | input | $clog2(MAX_DEG+1) | Field degree m, 2..MAX_DEG |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| inv_o | output | MAX_DEG | Inverse of the element, held until the next completion |

## Verification
The completion pulse of one operation and the acceptance of the next start can fall in the same cycle. This is because `busy_o` drops on the same edge on which `done_o` rises. The bench provokes this by raising `start_i` with new operands in the very cycle it sees `done_o`. It then judges that the old result stays on `inv_o` during the whole second operation. It also judges that the second result arrives exactly 2m edges later and is correct. A further case pulses `start_i` with different operands in the middle of a run, and confirms that the first result and its timing are unchanged.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

    // Sequencer phase of the inverter.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } gfinv_phase_e;

endpackage

// File: rtl/gfinv_step.sv
// One iteration of the shift/xor/swap inversion recurrence.
module gfinv_step #(
    parameter int W  = 9,
    parameter int JW = 5,
    parameter int DW = 4
) (
    input  logic [W-1:0]  r_i,
    input  logic [W-1:0]  s_i,
    input  logic [W-1:0]  u_i,
    input  logic [W-1:0]  v_i,
    input  logic [JW-1:0] j_i,
    input  logic [DW-1:0] deg_i,
    output logic [W-1:0]  r_o,
    output logic [W-1:0]  s_o,
    output logic [W-1:0]  u_o,
    output logic [W-1:0]  v_o,
    output logic [JW-1:0] j_o
);
    logic         r_top;
    logic         s_top;
    logic [W-1:0] s_red;
    logic [W-1:0] v_red;

    always_comb begin
        r_top = r_i[deg_i];
        s_top = s_i[deg_i];
        s_red = s_top ? (s_i ^ r_i) : s_i;
        v_red = s_top ? (v_i ^ u_i) : v_i;
        r_o   = r_i;
        s_o   = s_i;
        u_o   = u_i;
        v_o   = v_i;
        j_o   = j_i;
        if (!r_top) begin
            r_o = r_i << 1;
            u_o = u_i << 1;
            j_o = j_i + JW'(1);
        end else if (j_i == '0) begin
            r_o = s_red << 1;
            s_o = r_i;
            u_o = v_red << 1;
            v_o = u_i;
            j_o = JW'(1);
        end else begin
            s_o = s_red << 1;
            v_o = v_red;
            u_o = u_i >> 1;
            j_o = j_i - JW'(1);
        end
    end
endmodule

// File: rtl/gfinv_ctrl.sv
// Iteration sequencer: accepts a start when idle and runs 2*deg steps.
module gfinv_ctrl
    import gfinv_pkg::*;
#(
    parameter int MAX_DEG = 8,
    parameter int DW      = $clog2(MAX_DEG + 1),
    parameter int CW      = $clog2(2 * MAX_DEG + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [DW-1:0] deg_i,
    output logic          load_o,
    output logic          step_o,
    output logic          last_o,
    output logic          busy_o
);
    typedef struct packed {
        gfinv_phase_e  phase;
        logic [CW-1:0] left;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        load_o = 1'b0;
        step_o = 1'b0;
        last_o = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    load_o      = 1'b1;
                    seq_d.phase = PH_RUN;
                    seq_d.left  = CW'({deg_i, 1'b0});
                end
            end
            PH_RUN: begin
                step_o     = 1'b1;
                last_o     = (seq_q.left == CW'(1));
                seq_d.left = seq_q.left - CW'(1);
                if (last_o) begin
                    seq_d.phase = PH_IDLE;
                end
            end
            default: seq_d = seq_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{phase: PH_IDLE, left: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = (seq_q.phase == PH_RUN);

    // Running always has at least one step left (R2).
    assert_steps_left_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (seq_q.left != '0));
    // An accepted start leads to the running phase (R9).
    assert_busy_after_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);
    // A start while running does not reload the step count (R6).
    assert_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !last_o) |=> (seq_q.left == $past(seq_q.left) - CW'(1)));
endmodule

// File: rtl/gfinv_unit.sv
// GF(2^m) inverter top: operand registers, recurrence step, result register.
module gfinv_unit
    import gfinv_pkg::*;
#(
    parameter int MAX_DEG = 8,
    parameter int DW      = $clog2(MAX_DEG + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [MAX_DEG-1:0] elem_i,
    input  logic [MAX_DEG:0]   poly_i,
    input  logic [DW-1:0]      deg_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [MAX_DEG-1:0] inv_o
);
    localparam int W  = MAX_DEG + 1;
    localparam int JW = $clog2(2 * MAX_DEG + 2) + 1;

    typedef struct packed {
        logic [W-1:0]       r;
        logic [W-1:0]       s;
        logic [W-1:0]       u;
        logic [W-1:0]       v;
        logic [JW-1:0]      j;
        logic [DW-1:0]      deg;
        logic               zero;
        logic [MAX_DEG-1:0] res;
        logic               done;
    } dp_t;

    dp_t dp_d, dp_q;

    logic          load, step, last;
    logic [W-1:0]  r_nx, s_nx, u_nx, v_nx;
    logic [JW-1:0] j_nx;
    logic [W-1:0]  low_mask;

    gfinv_ctrl #(.MAX_DEG(MAX_DEG), .DW(DW)) u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(start_i),
        .deg_i  (deg_i),
        .load_o (load),
        .step_o (step),
        .last_o (last),
        .busy_o (busy_o)
    );

    gfinv_step #(.W(W), .JW(JW), .DW(DW)) u_step (
        .r_i  (dp_q.r),
        .s_i  (dp_q.s),
        .u_i  (dp_q.u),
        .v_i  (dp_q.v),
        .j_i  (dp_q.j),
        .deg_i(dp_q.deg),
        .r_o  (r_nx),
        .s_o  (s_nx),
        .u_o  (u_nx),
        .v_o  (v_nx),
        .j_o  (j_nx)
    );

    always_comb begin
        low_mask = (W'(1) << dp_q.deg) - W'(1);
        dp_d      = dp_q;
        dp_d.done = 1'b0;
        if (load) begin
            dp_d.r    = W'(elem_i);
            dp_d.s    = poly_i;
            dp_d.u    = W'(1);
            dp_d.v    = '0;
            dp_d.j    = '0;
            dp_d.deg  = deg_i;
            dp_d.zero = (elem_i == '0);
        end else if (step) begin
            dp_d.r = r_nx;
            dp_d.s = s_nx;
            dp_d.u = u_nx;
            dp_d.v = v_nx;
            dp_d.j = j_nx;
            if (last) begin
                dp_d.res  = dp_q.zero ? '0 : MAX_DEG'(u_nx & low_mask);
                dp_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign done_o = dp_q.done;
    assign inv_o  = dp_q.res;

    // Completion is a single-cycle pulse (R8).
    assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // Completion only follows a running operation (R2, R9).
    assert_done_after_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(busy_o) && !busy_o));
    // Result bits at or above the degree are clear (R4).
    assert_result_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((W'(inv_o) & ~low_mask) == '0));
    // A zero element yields a zero result (R5).
    assert_zero_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && dp_q.zero) |-> (inv_o == '0));
    // The result only moves on a completion (R7).
    assert_result_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(inv_o));
    // The balance counter stays within the iteration budget (R3).
    assert_balance_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (dp_q.j <= JW'({dp_q.deg, 1'b0})));
endmodule

// File: tb/gfinv_unit_bench.sv
module gfinv_unit_bench;
    localparam int MAX_DEG = 8;
    localparam int DW      = $clog2(MAX_DEG + 1);

    typedef struct packed {
        logic [3:0] deg;
        logic [8:0] poly;
        logic [7:0] a;
        logic [7:0] inv;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{deg: 4'd8, poly: 9'h11B, a: 8'h53, inv: 8'hCA},
        '{deg: 4'd8, poly: 9'h11B, a: 8'h01, inv: 8'h01},
        '{deg: 4'd8, poly: 9'h11B, a: 8'h02, inv: 8'h8D},
        '{deg: 4'd4, poly: 9'h013, a: 8'h02, inv: 8'h09},
        '{deg: 4'd3, poly: 9'h00B, a: 8'h02, inv: 8'h05},
        '{deg: 4'd2, poly: 9'h007, a: 8'h02, inv: 8'h03}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [MAX_DEG-1:0] elem = '0;
    logic [MAX_DEG:0]   poly = '0;
    logic [DW-1:0]      deg = '0;
    logic               busy, done;
    logic [MAX_DEG-1:0] inv;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    gfinv_unit #(.MAX_DEG(MAX_DEG)) u_gfinv_unit (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .start_i(start),
        .elem_i (elem),
        .poly_i (poly),
        .deg_i  (deg),
        .busy_o (busy),
        .done_o (done),
        .inv_o  (inv)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] gf_mul(input logic [7:0] x, input logic [7:0] y,
                                          input logic [8:0] p, input int m);
        logic [8:0] acc = '0;
        logic [8:0] a   = {1'b0, x};
        for (int i = 0; i < m; i++) begin
            if (y[i]) acc = acc ^ a;
            a = a << 1;
            if (a[m]) a = a ^ p;
        end
        return acc[7:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive a start at a falling edge, then count edges until done.
    task automatic run_op(input logic [7:0] a, input logic [8:0] p, input int m,
                          output logic [7:0] res, output int lat);
        start = 1'b1; elem = a; poly = p; deg = DW'(m);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 4 * MAX_DEG + 8) begin
            @(negedge clk);
            lat++;
            if (!done && lat < 2 * m) check("R9 busy during run", 32'(busy), 32'd1);
        end
        res = inv;
    endtask

    task automatic full_check(input logic [7:0] a, input logic [8:0] p, input int m,
                              input logic [7:0] exp, input logic use_exp);
        logic [7:0] res;
        int lat;
        run_op(a, p, m, res, lat);
        check("R2 latency", 32'(lat), 32'(2 * m));
        check("R9 busy low at done", 32'(busy), 32'd0);
        check("R4 high bits clear", 32'(res >> m), 32'd0);
        if (a == 8'h00) check("R5 zero element", 32'(res), 32'd0);
        else check("R3 product is one", 32'(gf_mul(a, res, p, m)), 32'd1);
        if (use_exp) check("R3 table value", 32'(res), 32'(exp));
        @(negedge clk);
        check("R8 done one cycle", 32'(done), 32'd0);
        check("R7 result held", 32'(inv), 32'(res));
    endtask

    initial begin
        logic [7:0] r1, r2;
        int l1, l2;
        repeat (3) @(negedge clk);
        check("R1 done reset", 32'(done), 32'd0);
        check("R1 busy reset", 32'(busy), 32'd0);
        check("R1 result reset", 32'(inv), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 6; k++) begin
            full_check(TBL[k].a, TBL[k].poly, int'(TBL[k].deg), TBL[k].inv, 1'b1);
        end

        // Sweeps over whole fields (R3, R4, R2).
        for (int a = 1; a < 256; a++) full_check(8'(a), 9'h11B, 8, 8'h00, 1'b0);
        for (int a = 1; a < 16; a++)  full_check(8'(a), 9'h019, 4, 8'h00, 1'b0);
        for (int a = 1; a < 8; a++)   full_check(8'(a), 9'h00D, 3, 8'h00, 1'b0);

        // Zero element at two degrees (R5).
        full_check(8'h00, 9'h11B, 8, 8'h00, 1'b0);
        full_check(8'h00, 9'h013, 4, 8'h00, 1'b0);

        // Start pulsed mid-run with other operands is ignored (R6).
        start = 1'b1; elem = 8'h53; poly = 9'h11B; deg = DW'(8);
        @(negedge clk);
        start = 1'b0;
        l1 = 0;
        repeat (3) begin @(negedge clk); l1++; end
        start = 1'b1; elem = 8'h07; poly = 9'h013; deg = DW'(4);
        @(negedge clk); l1++;
        start = 1'b0;
        while (!done && l1 < 40) begin @(negedge clk); l1++; end
        check("R6 latency kept", 32'(l1), 32'd16);
        check("R6 result kept", 32'(inv), 32'hCA);

        // Back-to-back: new start in the done cycle (R9, R7).
        r1 = inv;
        start = 1'b1; elem = 8'h02; poly = 9'h011B; deg = DW'(8);
        @(negedge clk);
        start = 1'b0;
        check("R9 start in done cycle accepted", 32'(busy), 32'd1);
        l2 = 0;
        while (!done && l2 < 40) begin
            @(negedge clk); l2++;
            if (!done) check("R7 old result held", 32'(inv), 32'(r1));
        end
        r2 = inv;
        check("R2 back-to-back latency", 32'(l2), 32'd16);
        check("R3 back-to-back value", 32'(r2), 32'h8D);
        @(negedge clk);

        // Idle with start low: nothing changes (R7).
        repeat (5) @(negedge clk);
        check("R7 idle hold", 32'(inv), 32'h8D);
        check("R8 idle done low", 32'(done), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule